// File: doc/BRIEF.md
# Device Slot Number Allocator

This block keeps track of which of the 32 device slot numbers on a single configuration bus are taken. It stores one occupancy bit per slot. Slot 0 belongs to the host bridge and is marked taken as soon as reset ends. A requester sends one request per cycle. The request asks for one of three things:

- automatic allocation of the lowest free slot;
- a claim on a named slot;
- the return of a named slot.

Every accepted request gets a registered response one cycle later. The response carries a 2-bit status code. After a successful automatic allocation it also carries the slot number that was granted.

The slot operand is one bit wider than a slot index. This lets the block see out-of-range numbers and reject them instead of wrapping them. The block has no record of which device owns a slot. Returning a slot only clears its occupancy bit.

Top module: `slot_alloc`

## Requirements
- R1: After reset, slot 0 is taken and slots 1 to 31 are free. `rsp_valid` is low until the first request. A claim of slot 0 after reset returns IN_USE (3). An automatic allocation after reset grants slot 1.
- R2: A request taken while `req_valid` is high produces `rsp_valid` high in the next cycle, and in that cycle only. In a cycle with no response, `rsp_status` and `rsp_slot` are 0 and the occupancy does not change.
- R3: Automatic allocation (`req_op` = 0) grants the lowest-numbered free slot and marks it taken. It returns status OK (0) with the granted number on `rsp_slot`.
- R4: Automatic allocation with every slot taken returns NO_SLOT (1) and changes no occupancy bit.
- R5: A claim (`req_op` = 1) of a free slot below 32 marks that slot taken and returns OK (0).
- R6: A claim of a slot that is already taken returns IN_USE (3), and the slot stays taken.
- R7: A claim or a return whose `req_slot` is 32 or more returns INVALID (2) and changes no occupancy bit.
- R8: A return (`req_op` = 2) of a slot below 32 frees that slot and returns OK (0). This holds even when the slot was already free.
- R9: Opcode 3 is reserved. It returns INVALID (2) and changes no occupancy bit.
- R10: `rsp_slot` is 0 in every response except a successful automatic allocation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | 0 automatic allocation, 1 claim, 2 return, 3 reserved |
| req_slot | input | 6 | Slot number for a claim or a return |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_status | output | 2 | 0 OK, 1 NO_SLOT, 2 INVALID, 3 IN_USE |
| rsp_slot | output | 5 | Granted slot after a successful automatic allocation, otherwise 0 |

## Verification
The assertions assume that `req_op` and `req_slot` have known values whenever `req_valid` is high. They also assume that a requester never depends on a response arriving in the same cycle as its request. The bench meets both by driving every input on the falling clock edge, with fully defined values, one request per cycle. Between bursts it inserts idle cycles with `req_valid` low.

To reach both boundaries of the pool, the stimulus fills every slot and also returns slot 0. It sends out-of-range numbers 32 and above, including the top code 63.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

    typedef enum logic [1:0] {
        OP_AUTO    = 2'd0,
        OP_CLAIM   = 2'd1,
        OP_RELEASE = 2'd2,
        OP_RSVD    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_NO_SLOT = 2'd1,
        ST_INVALID = 2'd2,
        ST_IN_USE  = 2'd3
    } status_e;

endpackage

// File: rtl/slot_alloc_first_free.sv
// Finds the lowest-numbered clear bit of the occupancy vector.
module slot_alloc_first_free #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] occ,
    output logic                 found,
    output logic [SLOT_W-1:0]    idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        // Walk downward so the last hit written is the lowest free slot.
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/slot_alloc_decode.sv
// Range check and one-hot select of the requested slot number.
module slot_alloc_decode #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int REQ_W     = SLOT_W + 1
) (
    input  logic [REQ_W-1:0]     slot,
    output logic                 in_range,
    output logic [NUM_SLOTS-1:0] onehot
);

    assign in_range = (slot < REQ_W'(NUM_SLOTS));

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
        assign onehot[g] = (slot == REQ_W'(g));
    end

endmodule

// File: rtl/slot_alloc.sv
module slot_alloc
    import slot_alloc_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int REQ_W     = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [REQ_W-1:0]  req_slot,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [SLOT_W-1:0] rsp_slot
);

    localparam logic [NUM_SLOTS-1:0] OCC_RESET = NUM_SLOTS'(1);

    typedef struct packed {
        logic [NUM_SLOTS-1:0] occ;
        logic                 rsp_valid;
        status_e              status;
        logic [SLOT_W-1:0]    slot;
    } state_t;

    state_t s_d, s_q;

    logic                 free_found;
    logic [SLOT_W-1:0]    free_idx;
    logic                 sel_in_range;
    logic [NUM_SLOTS-1:0] sel_onehot;
    logic [NUM_SLOTS-1:0] occ_q;

    assign occ_q = s_q.occ;

    slot_alloc_first_free #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_first_free (
        .occ   (s_q.occ),
        .found (free_found),
        .idx   (free_idx)
    );

    slot_alloc_decode #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .REQ_W     (REQ_W)
    ) u_decode (
        .slot     (req_slot),
        .in_range (sel_in_range),
        .onehot   (sel_onehot)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        s_d.status    = ST_OK;
        s_d.slot      = '0;
        if (req_valid) begin
            s_d.rsp_valid = 1'b1;
            unique case (op_e'(req_op))
                OP_AUTO: begin
                    if (free_found) begin
                        s_d.occ[free_idx] = 1'b1;
                        s_d.slot          = free_idx;
                    end else begin
                        s_d.status = ST_NO_SLOT;
                    end
                end
                OP_CLAIM: begin
                    if (!sel_in_range) begin
                        s_d.status = ST_INVALID;
                    end else if ((s_q.occ & sel_onehot) != '0) begin
                        s_d.status = ST_IN_USE;
                    end else begin
                        s_d.occ = s_q.occ | sel_onehot;
                    end
                end
                OP_RELEASE: begin
                    if (!sel_in_range) begin
                        s_d.status = ST_INVALID;
                    end else begin
                        s_d.occ = s_q.occ & ~sel_onehot;
                    end
                end
                default: begin
                    s_d.status = ST_INVALID;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.occ       <= OCC_RESET;
            s_q.rsp_valid <= 1'b0;
            s_q.status    <= ST_OK;
            s_q.slot      <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid  = s_q.rsp_valid;
    assign rsp_status = s_q.status;
    assign rsp_slot   = s_q.slot;

endmodule

// File: rtl/slot_alloc_chk.sv
module slot_alloc_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int REQ_W     = SLOT_W + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [1:0]           req_op,
    input logic [REQ_W-1:0]     req_slot,
    input logic                 rsp_valid,
    input logic [1:0]           rsp_status,
    input logic [SLOT_W-1:0]    rsp_slot,
    input logic [NUM_SLOTS-1:0] occ
);

    logic [NUM_SLOTS-1:0] occ_prev;
    logic [SLOT_W-1:0]    req_idx;
    logic                 req_ok_range;

    assign req_idx      = req_slot[SLOT_W-1:0];
    assign req_ok_range = (req_slot < REQ_W'(NUM_SLOTS));

    always_ff @(posedge clk) begin
        if (!rst_n) occ_prev <= '0;
        else        occ_prev <= occ;
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(occ))); // R2
    AST_AUTO_GRANTS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && occ != '1) |=>
            (rsp_status == 2'd0 && occ[rsp_slot] && !occ_prev[rsp_slot])); // R3
    AST_FULL_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && occ == '1) |=>
            (rsp_status == 2'd1 && $stable(occ))); // R4
    AST_CLAIM_IN_USE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1 && req_ok_range && occ[req_idx]) |=>
            (rsp_status == 2'd3 && $stable(occ))); // R6
    AST_RANGE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 2'd1 || req_op == 2'd2) && !req_ok_range) |=>
            (rsp_status == 2'd2 && $stable(occ))); // R7
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2 && req_ok_range) |=>
            (rsp_status == 2'd0 && !occ[$past(req_idx)])); // R8
    AST_RSVD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> (rsp_status == 2'd2 && $stable(occ))); // R9
    AST_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_slot == '0)); // R10

endmodule

bind slot_alloc slot_alloc_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .REQ_W     (REQ_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_slot   (req_slot),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_slot   (rsp_slot),
    .occ        (occ_q)
);

// File: tb/slot_alloc_bench.sv
`timescale 1ns/1ps
module slot_alloc_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [5:0] req_slot = 6'd0;
    logic       rsp_valid;
    logic [1:0] rsp_status;
    logic [4:0] rsp_slot;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Behavioural reference: occupancy as an int array.
    int mdl[32];
    int exp_valid, exp_status, exp_slot;

    always #2.5 clk = ~clk;

    slot_alloc u_slot_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_slot   (req_slot),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_slot   (rsp_slot)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 50000", cycles);
            finish_run();
        end
    end

    // Model one cycle, drive on the falling edge, compare after the rising edge.
    task automatic step(input bit v, input int op, input int slot, input string req);
        @(negedge clk);
        req_valid = v;
        req_op    = 2'(op);
        req_slot  = 6'(slot);
        exp_valid = v; exp_status = 0; exp_slot = 0;
        if (v) begin
            case (op)
                0: begin
                    exp_status = 1;
                    for (int i = 0; i < 32; i++) begin
                        if (mdl[i] == 0 && exp_status == 1) begin
                            exp_status = 0; exp_slot = i; mdl[i] = 1;
                        end
                    end
                end
                1: begin
                    if (slot >= 32) exp_status = 2;
                    else if (mdl[slot] != 0) exp_status = 3;
                    else mdl[slot] = 1;
                end
                2: begin
                    if (slot >= 32) exp_status = 2;
                    else mdl[slot] = 0;
                end
                default: exp_status = 2;
            endcase
        end
        @(posedge clk);
        #1;
        checks++;
        if (rsp_valid !== 1'(exp_valid) || rsp_status !== 2'(exp_status) ||
            rsp_slot !== 5'(exp_slot)) begin
            errors++;
            $display("FAIL %s: op=%0d slot=%0d actual v=%0b st=%0d sl=%0d expected v=%0d st=%0d sl=%0d",
                     req, op, slot, rsp_valid, rsp_status, rsp_slot,
                     exp_valid, exp_status, exp_slot);
        end
    endtask

    initial begin
        foreach (mdl[i]) mdl[i] = 0;
        mdl[0] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rsp_valid after reset actual=%0b expected=0", rsp_valid);
        end
        step(0, 0, 0, "R2 idle");
        step(1, 1, 0, "R1 slot0 held");
        step(1, 0, 0, "R1 first auto gets 1");
        step(0, 0, 0, "R2 idle gap");
        for (int k = 0; k < 30; k++) step(1, 0, 0, "R3 fill");
        step(1, 0, 0, "R4 full");
        step(1, 0, 0, "R4 full again");
        step(1, 2, 5, "R8 release 5");
        step(1, 0, 0, "R3 auto returns 5");
        step(1, 1, 7, "R6 claim taken");
        step(1, 1, 32, "R7 claim 32");
        step(1, 2, 63, "R7 release 63");
        step(1, 3, 9, "R9 reserved op");
        step(1, 0, 0, "R9 R7 state kept");
        step(1, 2, 10, "R8 release 10");
        step(1, 2, 10, "R8 release free 10");
        step(1, 1, 10, "R5 claim free 10");
        step(1, 1, 10, "R6 claim 10 again");
        step(1, 2, 0, "R8 release slot 0");
        step(1, 2, 31, "R8 release 31");
        step(1, 0, 0, "R3 auto gets 0");
        step(1, 1, 31, "R5 claim top slot");
        step(1, 2, 3, "R8 release 3");
        step(1, 2, 2, "R8 release 2");
        step(0, 0, 0, "R2 idle");
        step(1, 0, 0, "R3 lowest is 2 R10");
        step(1, 0, 0, "R3 next is 3");
        step(1, 1, 12, "R10 claim no slot echo");
        step(0, 0, 0, "R2 quiet");
        finish_run();
    end

endmodule